// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial slave and a byte-wide memory array. The slave hands it the word address of a write transaction and then each data byte it receives. The block keeps those bytes in a small page-sized buffer. Each entry has a flag that records whether it was written. The byte pointer moves only inside the selected page, so a long burst wraps back to the start of the same page and overwrites what it stored there before.

When the slave reports a stop condition after at least one data byte, the block starts a self-timed programming cycle. The cycle length is a parameter counted in system clocks. In the first clocks of the cycle the block walks the buffer once and issues one array write for each flagged entry, so bytes that were never received stay as they were. For the whole cycle it raises a busy flag. The slave uses that flag to ignore the bus and withhold the acknowledge of its address byte, which lets a host poll for completion. A write-protect level that is high at the stop throws the collected bytes away, and no cycle starts.

Top module: `pwb_top`

## Requirements
- R1: Reset is synchronous and active-low. After reset `busy`, `cycle_done` and `mem_we` are low and the buffer holds no flagged entry.
- R2: `word_addr[6:3]` selects the page and `word_addr[2:0]` the starting offset. Each accepted data byte goes to the current offset. Then only the offset advances, modulo 8, so offset 7 is followed by offset 0 of the same page.
- R3: When more than 8 bytes arrive in one transaction, a later byte replaces the earlier byte at the same offset, and only the last value is committed.
- R4: Only offsets that received a byte in the transaction are written to the array. All other addresses of the page keep their contents.
- R5: A stop with at least one flagged entry and `wp` low raises `busy` on the next clock. `busy` then stays high for exactly WR_CYCLES clocks. `cycle_done` pulses high for one clock in the last of them.
- R6: In busy clock k, for k from 0 to 7, `mem_we` is high exactly when offset k was flagged, with `mem_addr = {page, k}` and `mem_wdata` equal to that entry. `mem_we` is never high while `busy` is low.
- R7: While `busy` is high, `addr_load`, `data_strobe` and `stop_seen` have no effect. Nothing they carry is written, the cycle length is unchanged, and no entry is left pending after the cycle.
- R8: A stop that follows only an address load, with no data byte, starts no cycle.
- R9: With `wp` high at the stop, no cycle starts and nothing is written. The collected bytes are discarded, so a later stop without data also starts nothing.
- R10: An address load starts a new transaction. Entries flagged before it are dropped and are never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp | input | 1 | Write protect, high blocks commits |
| addr_load | input | 1 | Pulse: word address of a write received |
| word_addr | input | 7 | Word address (page in bits 6:3, offset in bits 2:0) |
| data_strobe | input | 1 | Pulse: a data byte received |
| data_byte | input | 8 | Received data byte |
| stop_seen | input | 1 | Pulse: stop condition seen |
| busy | output | 1 | Programming cycle in progress (withhold acknowledge) |
| cycle_done | output | 1 | One-clock pulse in the last busy clock |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The write path is exercised with four patterns. A single byte separates a correct commit from one that writes the whole page. A burst that starts at offset 6 and crosses the page end separates in-page wrapping from a carry into the page bits. A ten-byte burst separates overwriting from appending. A write issued while a cycle is already running separates real input gating from a buffer that merely happens to be written late. Three further patterns have to leave the array untouched: an address-only stop, a stop under write protect, and a repeated address load. They tell the launch condition apart from a plain stop detector. A reference model predicts `busy`, `cycle_done` and every array write on every clock, so a shifted or stretched cycle shows up in the first clock where it differs.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
// Package: types shared by the page write buffer modules.
// Assumes nothing beyond the standard SystemVerilog type system.
package pwb_pkg;
    // Programming controller state: idle or running a timed cycle.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } wr_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
`timescale 1ns/1ps
// Module: pwb_page_buf
// Holds one page worth of data bytes, a written flag per entry, the page
// number and the in-page byte pointer of the current write transaction.
// Assumes PAGE_BYTES is a power of two, so the pointer wraps by overflow.
module pwb_page_buf #(
    parameter int PAGE_BYTES = 8,
    parameter int PAGES      = 16,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [PAGE_W-1:0] load_page,
    input  logic [OFF_W-1:0]  load_off,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              clr,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [PAGE_W-1:0] page_q,
    output logic              any_written,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [OFF_W-1:0]  off_q;
    logic [PAGE_BYTES-1:0] flag_q;
    logic [DATA_W-1:0] ent_q [PAGE_BYTES];

    // Page register and in-page pointer; only the pointer advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (load_addr) begin
            page_q <= load_page;
            off_q  <= load_off;
        end else if (byte_we) begin
            off_q  <= off_q + 1'b1;
        end
    end

    // One storage slot and written flag per page offset.
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_ent
        // Flag set on a byte to this slot, cleared by new address or clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (clr || load_addr)
                flag_q[i] <= 1'b0;
            else if (byte_we && off_q == OFF_W'(i))
                flag_q[i] <= 1'b1;
        end
        // Data slot overwritten by every byte aimed at this offset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[i] <= '0;
            else if (byte_we && off_q == OFF_W'(i))
                ent_q[i] <= byte_in;
        end
    end

    // Read port used by the commit scan.
    always_comb begin
        any_written = |flag_q;
        rd_valid    = flag_q[rd_idx];
        rd_data     = ent_q[rd_idx];
    end
endmodule

// File: rtl/pwb_cycle_ctrl.sv
`timescale 1ns/1ps
// Module: pwb_cycle_ctrl
// Runs the self-timed programming cycle: WR_CYCLES clocks of busy, with a
// scan index over the page in the first PAGE_BYTES clocks and a done pulse
// in the last one. Assumes WR_CYCLES > PAGE_BYTES.
module pwb_cycle_ctrl
    import pwb_pkg::*;
#(
    parameter int WR_CYCLES  = 250000,
    parameter int PAGE_BYTES = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    output logic             busy,
    output logic             done,
    output logic             scan_act,
    output logic [OFF_W-1:0] scan_idx
);
    wr_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_c;

    // Detect the final clock of the cycle.
    always_comb last_c = (cnt_q == CNT_W'(WR_CYCLES - 1));

    // State and clock counter of the programming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (launch) begin
                    st_q  <= ST_PROG;
                    cnt_q <= '0;
                end
                ST_PROG: if (last_c) begin
                    st_q  <= ST_IDLE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Status and scan outputs decoded from state and counter.
    always_comb begin
        busy     = (st_q == ST_PROG);
        done     = busy && last_c;
        scan_act = busy && (cnt_q < CNT_W'(PAGE_BYTES));
        scan_idx = cnt_q[OFF_W-1:0];
    end
endmodule

// File: rtl/pwb_top.sv
`timescale 1ns/1ps
// Module: pwb_top
// Page write buffer with timed commit. Collects the data bytes of a write
// transaction, and on stop commits only the written entries during a timed
// busy period. Assumes the slave never pulses addr_load, data_strobe and
// stop_seen in the same clock, and treats busy as "withhold acknowledge".
module pwb_top #(
    parameter int PAGE_BYTES = 8,
    parameter int PAGES      = 16,
    parameter int DATA_W     = 8,
    parameter int WR_CYCLES  = 250000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = $clog2(PAGES),
    localparam int ADDR_W    = OFF_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              data_strobe,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              stop_seen,
    output logic              busy,
    output logic              cycle_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic              accept, ld, bw, stop_ok, launch, clr;
    logic [PAGE_W-1:0] page_q;
    logic              any_written, rd_valid, scan_act;
    logic [OFF_W-1:0]  scan_idx;
    logic [DATA_W-1:0] rd_data;

    // Input gating and launch decision; all inputs are dead while busy.
    always_comb begin
        accept  = !busy;
        ld      = accept && addr_load;
        bw      = accept && data_strobe && !addr_load;
        stop_ok = accept && stop_seen;
        launch  = stop_ok && any_written && !wp;
        clr     = (stop_ok && !launch) || cycle_done;
    end

    pwb_page_buf #(
        .PAGE_BYTES(PAGE_BYTES),
        .PAGES     (PAGES),
        .DATA_W    (DATA_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_addr  (ld),
        .load_page  (word_addr[ADDR_W-1:OFF_W]),
        .load_off   (word_addr[OFF_W-1:0]),
        .byte_we    (bw),
        .byte_in    (data_byte),
        .clr        (clr),
        .rd_idx     (scan_idx),
        .page_q     (page_q),
        .any_written(any_written),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    pwb_cycle_ctrl #(
        .WR_CYCLES (WR_CYCLES),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .busy    (busy),
        .done    (cycle_done),
        .scan_act(scan_act),
        .scan_idx(scan_idx)
    );

    // Array write port driven by the commit scan.
    always_comb begin
        mem_we    = scan_act && rd_valid;
        mem_addr  = {page_q, scan_idx};
        mem_wdata = rd_data;
    end
endmodule

// File: rtl/pwb_checker.sv
`timescale 1ns/1ps
// Module: pwb_checker
// Temporal properties of pwb_top, attached by bind below.
module pwb_checker #(
    parameter int ADDR_W = 7,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp,
    input logic              addr_load,
    input logic              stop_seen,
    input logic              busy,
    input logic              cycle_done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    // R6: array writes only inside a busy period.
    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R5: a cycle begins only after an unprotected stop.
    p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_seen) && !$past(wp)));

    // R5: done is a single clock and ends the busy period.
    p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (!busy && !cycle_done));

    // R7: inputs cannot cut a running cycle short.
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cycle_done) |=> busy);

    // R9: a protected stop never starts a cycle.
    p_wp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_seen && wp) |=> !busy);

    // R8: an address load alone never starts a cycle.
    p_addr_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && addr_load) |=> !busy);

    // R2: the page part of the write address is fixed within a cycle.
    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));
endmodule

bind pwb_top pwb_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp        (wp),
    .addr_load (addr_load),
    .stop_seen (stop_seen),
    .busy      (busy),
    .cycle_done(cycle_done),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/sim_pwb_top.sv
`timescale 1ns/1ps
module sim_pwb_top;
    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp = 1'b0;
    logic       addr_load = 1'b0;
    logic [6:0] word_addr = '0;
    logic       data_strobe = 1'b0;
    logic [7:0] data_byte = '0;
    logic       stop_seen = 1'b0;
    logic       busy, cycle_done, mem_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    int busy_cycles = 0;
    int done_cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwb_top #(.WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .wp(wp), .addr_load(addr_load),
        .word_addr(word_addr), .data_strobe(data_strobe),
        .data_byte(data_byte), .stop_seen(stop_seen), .busy(busy),
        .cycle_done(cycle_done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Mock array written through the block's write port.
    logic [7:0] arr [128];
    initial for (int i = 0; i < 128; i++) arr[i] = 8'hEE;
    always @(posedge clk) if (mem_we) arr[mem_addr] = mem_wdata;

    // Behavioural reference model, updated on each rising edge.
    bit       m_busy = 0;
    int       m_cnt = 0;
    bit [7:0] m_flag = '0;
    int       m_page = 0;
    int       m_off = 0;
    int       m_buf [8];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_flag = '0; m_page = 0; m_off = 0;
        end else if (m_busy) begin
            if (m_cnt == WR - 1) begin
                m_busy = 0; m_flag = '0;
            end else m_cnt++;
        end else begin
            if (addr_load) begin
                m_page = int'(word_addr) / 8; m_off = int'(word_addr) % 8; m_flag = '0;
            end else if (data_strobe) begin
                m_buf[m_off] = int'(data_byte); m_flag[m_off] = 1'b1; m_off = (m_off + 1) % 8;
            end
            if (stop_seen) begin
                if (m_flag != 0 && !wp) begin m_busy = 1; m_cnt = 0; end
                else m_flag = '0;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_we;
            exp_we = m_busy && m_cnt < 8 && m_flag[m_cnt % 8];
            chk(busy == m_busy, "R5 busy", busy, m_busy);
            chk(cycle_done == (m_busy && m_cnt == WR - 1), "R5 done", cycle_done, m_busy && m_cnt == WR - 1);
            chk(mem_we == exp_we, "R6 mem_we", mem_we, exp_we);
            if (exp_we && mem_we) begin
                chk(int'(mem_addr) == m_page * 8 + m_cnt, "R6 mem_addr", mem_addr, m_page * 8 + m_cnt);
                chk(int'(mem_wdata) == m_buf[m_cnt], "R6 mem_wdata", mem_wdata, m_buf[m_cnt]);
            end
            if (busy) busy_cycles++;
            if (cycle_done) done_cycles++;
        end
    end

    task automatic send_addr(input int a);
        @(negedge clk); addr_load = 1'b1; word_addr = 7'(a);
        @(negedge clk); addr_load = 1'b0;
    endtask
    task automatic send_byte(input int d);
        @(negedge clk); data_strobe = 1'b1; data_byte = 8'(d);
        @(negedge clk); data_strobe = 1'b0;
    endtask
    task automatic send_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask
    task automatic settle();
        repeat (WR + 10) @(negedge clk);
    endtask
    task automatic clear_counts();
        busy_cycles = 0; done_cycles = 0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(mem_we == 0, "R1 mem_we", mem_we, 0);
        chk(cycle_done == 0, "R1 done", cycle_done, 0);

        // Single byte write: R2 placement, R4 neighbours, R5 length
        clear_counts();
        send_addr('h15); send_byte('hA5); send_stop();
        settle();
        chk(arr['h15] == 8'hA5, "R2 single byte", arr['h15], 'hA5);
        chk(arr['h14] == 8'hEE, "R4 lower neighbour", arr['h14], 'hEE);
        chk(arr['h16] == 8'hEE, "R4 upper neighbour", arr['h16], 'hEE);
        chk(busy_cycles == WR, "R5 busy length", busy_cycles, WR);
        chk(done_cycles == 1, "R5 one done pulse", done_cycles, 1);

        // Wrap inside page 5 from offset 6: R2 wrap, R4 untouched middle
        send_addr('h2E); send_byte('h11); send_byte('h22); send_byte('h33); send_stop();
        settle();
        chk(arr['h2E] == 8'h11, "R2 offset 6", arr['h2E], 'h11);
        chk(arr['h2F] == 8'h22, "R2 offset 7", arr['h2F], 'h22);
        chk(arr['h28] == 8'h33, "R2 wrap to offset 0", arr['h28], 'h33);
        chk(arr['h30] == 8'hEE, "R2 next page untouched", arr['h30], 'hEE);
        chk(arr['h2A] == 8'hEE, "R4 unwritten offset", arr['h2A], 'hEE);

        // Ten bytes from offset 0 of page 8: R3 overwrite
        send_addr('h40);
        for (int i = 0; i < 10; i++) send_byte('h50 + i);
        send_stop();
        settle();
        chk(arr['h40] == 8'h58, "R3 offset 0 overwritten", arr['h40], 'h58);
        chk(arr['h41] == 8'h59, "R3 offset 1 overwritten", arr['h41], 'h59);
        chk(arr['h47] == 8'h57, "R3 offset 7 kept", arr['h47], 'h57);

        // Traffic during busy: R7
        clear_counts();
        send_addr('h08); send_byte('h3C); send_stop();
        send_addr('h00); send_byte('h77); send_stop();
        settle();
        chk(arr['h08] == 8'h3C, "R7 first write done", arr['h08], 'h3C);
        chk(arr['h00] == 8'hEE, "R7 busy-time byte ignored", arr['h00], 'hEE);
        chk(busy_cycles == WR, "R7 cycle length unchanged", busy_cycles, WR);
        clear_counts();
        send_stop();
        settle();
        chk(busy_cycles == 0, "R7 nothing pending", busy_cycles, 0);

        // Address-only transaction: R8
        clear_counts();
        send_addr('h50); send_stop();
        settle();
        chk(busy_cycles == 0, "R8 no cycle", busy_cycles, 0);

        // Write protect: R9
        clear_counts();
        wp = 1'b1;
        send_addr('h60); send_byte('h99); send_stop();
        settle();
        chk(busy_cycles == 0, "R9 no cycle under wp", busy_cycles, 0);
        wp = 1'b0;
        send_stop();
        settle();
        chk(busy_cycles == 0, "R9 bytes discarded", busy_cycles, 0);
        chk(arr['h60] == 8'hEE, "R9 array untouched", arr['h60], 'hEE);

        // New address drops earlier bytes: R10
        clear_counts();
        send_addr('h70); send_byte('hC1);
        send_addr('h78); send_byte('hC2); send_stop();
        settle();
        chk(arr['h70] == 8'hEE, "R10 dropped byte", arr['h70], 'hEE);
        chk(arr['h78] == 8'hC2, "R10 new byte", arr['h78], 'hC2);
        chk(busy_cycles == WR, "R10 one cycle", busy_cycles, WR);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule